// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block watches for runaway software on a microcontroller. A prescaler divides the CPU clock, and each prescaler pulse decrements a down counter (15 bits by default). Software has to write the refresh strobe again before the counter passes zero. If it does not, the block raises a one-cycle request. The request is an interrupt while the action bit is clear and a reset request once that bit is set. Software can set the action bit but cannot clear it.

Both the counter and the prescaler stay idle after reset, and the first refresh write starts them. The divide ratio depends on the CPU clock source. On the main clock a ratio bit picks the low or the high divisor. On the sub-clock a fixed small divisor applies. A protect bit gates writes to the action bit and to the count-source bit. When both of those bits are set, the counter is in protective mode: it ignores the prescaler and steps once per strobe from a free-running oscillator. A hold input, raised for stop, wait or hold states, freezes the counter and the prescaler until it is released.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `count_value` reads the full value 2^CNT_W-1, `rst_sel`, `src_sel` and `prot_en` read 0, and no request is raised however long the block waits before the first refresh.
- R2: Any refresh write loads the full value into the counter on that clock edge and starts counting. A refresh does not restart the prescaler, so the next decrement keeps the prescaler's existing phase.
- R3: On the main clock (`cpu_on_sub`=0), the ratio bit selects DIV_LO when 0 and DIV_HI when 1. The first request comes exactly divisor × 2^CNT_W clock edges after the refresh edge.
- R4: On the sub-clock (`cpu_on_sub`=1), the divisor is DIV_SUB whatever the value of the ratio bit.
- R5: On underflow the block pulses `wdt_irq` if `rst_sel`=0 and `wdt_rst` if `rst_sel`=1. The pulse lasts exactly one cycle and the two outputs are never high together.
- R6: A mode write can set `rst_sel` to 1. No later write clears it; only `rst_n` does.
- R7: A mode write changes `rst_sel` and `src_sel` only while `prot_en`=1. `prot_en` follows `prot_wdata` on each `prot_wr`.
- R8: While `rst_sel`=1 and `src_sel`=1, the counter decrements once per `osc_tick` strobe and not at all on prescaler pulses. Underflow follows exactly 2^CNT_W strobes after a refresh.
- R9: While `hold`=1, the counter and the prescaler keep their values. After `hold` falls, counting resumes, so the period is longer by exactly the number of held cycles.
- R10: When the counter underflows, it reloads the full value and keeps counting, so later requests come every divisor × 2^CNT_W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| refresh_we | input | 1 | Refresh write strobe: reloads the counter and starts it |
| prot_wr | input | 1 | Write strobe for the protect bit |
| prot_wdata | input | 1 | New protect-bit value |
| mode_wr | input | 1 | Write strobe for the action and count-source bits |
| mode_rst_wdata | input | 1 | Action bit data: 1 selects a reset request |
| mode_src_wdata | input | 1 | Count-source bit data: 1 selects the oscillator |
| ratio_wr | input | 1 | Write strobe for the ratio bit |
| ratio_wdata | input | 1 | Ratio bit data: 0 selects DIV_LO, 1 selects DIV_HI |
| cpu_on_sub | input | 1 | 1 while the CPU runs from the sub-clock |
| hold | input | 1 | Freeze request for stop, wait or hold states |
| osc_tick | input | 1 | One-cycle strobe per oscillator period, already synchronised |
| wdt_irq | output | 1 | One-cycle interrupt request on underflow |
| wdt_rst | output | 1 | One-cycle reset request on underflow |
| count_value | output | CNT_W | Current counter value |
| prot_en | output | 1 | Current protect bit |
| rst_sel | output | 1 | Current action bit |
| src_sel | output | 1 | Current count-source bit |

## Verification
The assertions check the local rules on every cycle: the action bit never falls, locked mode writes leave both mode bits unchanged, a refresh or an underflow leaves the counter full, each decrement lowers the count by exactly one, hold and a missing oscillator strobe leave the count unchanged, and the requests are exclusive one-cycle pulses. Only the bench scenarios can show the timing that spans a whole period. These are the exact cycle counts for each divisor and for the sub-clock, that a refresh keeps the prescaler's phase, the period stretched by a hold window, and the strobe count to underflow in protective mode. The bench checks them against figures it computes from the divisors and the counter width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Decrement source of the down counter
  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_PRESCALE = 2'd1,
    SRC_OSC      = 2'd2
  } wdt_src_e;

  // Prescaler divisor from the CPU clock source and the ratio bit
  function automatic int unsigned pick_divisor(
    input logic        on_sub,
    input logic        ratio_hi,
    input int unsigned d_lo,
    input int unsigned d_hi,
    input int unsigned d_sub
  );
    if (on_sub)        return d_sub;
    else if (ratio_hi) return d_hi;
    else               return d_lo;
  endfunction

  function automatic int unsigned max3(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c
  );
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Clock edges from refresh to request for a given divisor
  function automatic int unsigned period_cycles(
    input int unsigned div,
    input int unsigned cnt_w
  );
    return div << cnt_w;
  endfunction

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_wr,
  input  logic prot_wdata,
  input  logic mode_wr,
  input  logic mode_rst_wdata,
  input  logic mode_src_wdata,
  input  logic ratio_wr,
  input  logic ratio_wdata,
  input  logic refresh_we,
  output logic prot_en,
  output logic rst_sel,
  output logic src_sel,
  output logic ratio_hi,
  output logic started
);

  logic prot_q, rst_sel_q, src_sel_q, ratio_q, started_q;
  logic mode_accept;

  // Mode bits change only while the protect bit is open
  assign mode_accept = mode_wr && prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q    <= 1'b0;
      rst_sel_q <= 1'b0;
      src_sel_q <= 1'b0;
      ratio_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (prot_wr)    prot_q    <= prot_wdata;
      if (ratio_wr)   ratio_q   <= ratio_wdata;
      if (refresh_we) started_q <= 1'b1;
      // action bit can only be raised by software
      rst_sel_q <= rst_sel_q | (mode_accept & mode_rst_wdata);
      if (mode_accept) src_sel_q <= mode_src_wdata;
    end
  end

  assign prot_en  = prot_q;
  assign rst_sel  = rst_sel_q;
  assign src_sel  = src_sel_q;
  assign ratio_hi = ratio_q;
  assign started  = started_q;

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sel_q |=> rst_sel_q);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !prot_q) |=> ($stable(rst_sel_q) && $stable(src_sel_q)));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_we |=> started_q);

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned DIV_LO  = 16,
  parameter int unsigned DIV_HI  = 128,
  parameter int unsigned DIV_SUB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic on_sub,
  input  logic ratio_hi,
  output logic tick
);
  import wdt_pkg::*;

  localparam int unsigned DMAX = max3(DIV_LO, DIV_HI, DIV_SUB);
  localparam int unsigned PW   = $clog2(DMAX) + 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;
  logic          at_limit;

  always_comb limit = PW'(pick_divisor(on_sub, ratio_hi, DIV_LO, DIV_HI, DIV_SUB) - 1);

  // ">=" keeps the wrap safe if the ratio drops while the phase is high
  assign at_limit = (pre_q >= limit);
  assign tick     = run && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (run)     pre_q <= at_limit ? '0 : pre_q + 1'b1;
  end

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pre_q));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             started,
  input  logic             refresh,
  input  logic             dec,
  input  logic             rst_sel,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             rst_req,
  output logic             underflow
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             irq_q, rst_q;
  logic             dec_eff;

  assign dec_eff   = started && dec;
  assign underflow = dec_eff && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= FULL;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (refresh || underflow) count_q <= FULL;
      else if (dec_eff)         count_q <= count_q - 1'b1;
      irq_q <= underflow && !rst_sel;
      rst_q <= underflow &&  rst_sel;
    end
  end

  assign count   = count_q;
  assign irq     = irq_q;
  assign rst_req = rst_q;

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (count_q == FULL && !irq_q && !rst_q));

  p_refresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (count_q == FULL));

  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_eff && !refresh && count_q != '0) |=> (count_q == CNT_W'($past(count_q) - 1'b1)));

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rst_q));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned DIV_LO  = 16,
  parameter int unsigned DIV_HI  = 128,
  parameter int unsigned DIV_SUB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_we,
  input  logic             prot_wr,
  input  logic             prot_wdata,
  input  logic             mode_wr,
  input  logic             mode_rst_wdata,
  input  logic             mode_src_wdata,
  input  logic             ratio_wr,
  input  logic             ratio_wdata,
  input  logic             cpu_on_sub,
  input  logic             hold,
  input  logic             osc_tick,
  output logic             wdt_irq,
  output logic             wdt_rst,
  output logic [CNT_W-1:0] count_value,
  output logic             prot_en,
  output logic             rst_sel,
  output logic             src_sel
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic     ratio_hi, started, prot_mode;
  logic     pre_tick, dec, underflow;
  wdt_src_e src;

  wdt_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .prot_wr        (prot_wr),
    .prot_wdata     (prot_wdata),
    .mode_wr        (mode_wr),
    .mode_rst_wdata (mode_rst_wdata),
    .mode_src_wdata (mode_src_wdata),
    .ratio_wr       (ratio_wr),
    .ratio_wdata    (ratio_wdata),
    .refresh_we     (refresh_we),
    .prot_en        (prot_en),
    .rst_sel        (rst_sel),
    .src_sel        (src_sel),
    .ratio_hi       (ratio_hi),
    .started        (started)
  );

  // Protective mode needs both the reset action and the oscillator source
  assign prot_mode = rst_sel && src_sel;

  always_comb begin
    if (!started || hold) src = SRC_NONE;
    else if (prot_mode)   src = SRC_OSC;
    else                  src = SRC_PRESCALE;
  end

  wdt_prescale #(
    .DIV_LO  (DIV_LO),
    .DIV_HI  (DIV_HI),
    .DIV_SUB (DIV_SUB)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (src == SRC_PRESCALE),
    .on_sub   (cpu_on_sub),
    .ratio_hi (ratio_hi),
    .tick     (pre_tick)
  );

  always_comb begin
    case (src)
      SRC_PRESCALE: dec = pre_tick;
      SRC_OSC:      dec = osc_tick;
      default:      dec = 1'b0;
    endcase
  end

  wdt_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .started   (started),
    .refresh   (refresh_we),
    .dec       (dec),
    .rst_sel   (rst_sel),
    .count     (count_value),
    .irq       (wdt_irq),
    .rst_req   (wdt_rst),
    .underflow (underflow)
  );

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !refresh_we) |=> $stable(count_value));

  p_osc_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode && !osc_tick && !refresh_we) |=> $stable(count_value));

  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (count_value == FULL));

  p_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (wdt_irq != wdt_rst));

endmodule

// File: tb/test_wdt_guard.sv
`timescale 1ns/1ps
module test_wdt_guard;
  localparam int W    = 5;
  localparam int N    = 1 << W;
  localparam int DLO  = 4;
  localparam int DHI  = 8;
  localparam int DSUB = 2;
  localparam int FULL = N - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, refresh_we, prot_wr, prot_wdata, mode_wr, mode_rst_wdata, mode_src_wdata;
  logic ratio_wr, ratio_wdata, cpu_on_sub, hold, osc_tick;
  logic wdt_irq, wdt_rst, prot_en, rst_sel, src_sel;
  logic [W-1:0] count_value;

  wdt_guard #(.CNT_W(W), .DIV_LO(DLO), .DIV_HI(DHI), .DIV_SUB(DSUB)) i_wdt_guard (
    .clk(clk), .rst_n(rst_n), .refresh_we(refresh_we), .prot_wr(prot_wr),
    .prot_wdata(prot_wdata), .mode_wr(mode_wr), .mode_rst_wdata(mode_rst_wdata),
    .mode_src_wdata(mode_src_wdata), .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata),
    .cpu_on_sub(cpu_on_sub), .hold(hold), .osc_tick(osc_tick), .wdt_irq(wdt_irq),
    .wdt_rst(wdt_rst), .count_value(count_value), .prot_en(prot_en),
    .rst_sel(rst_sel), .src_sel(src_sel)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; refresh_we = 0; prot_wr = 0; prot_wdata = 0; mode_wr = 0;
    mode_rst_wdata = 0; mode_src_wdata = 0; ratio_wr = 0; ratio_wdata = 0;
    cpu_on_sub = 0; hold = 0; osc_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse_refresh;
    refresh_we = 1; @(negedge clk); refresh_we = 0;
  endtask

  task automatic wr_prot(input logic v);
    prot_wr = 1; prot_wdata = v; @(negedge clk); prot_wr = 0;
  endtask

  task automatic wr_mode(input logic r, input logic s);
    mode_wr = 1; mode_rst_wdata = r; mode_src_wdata = s; @(negedge clk); mode_wr = 0;
  endtask

  task automatic wr_ratio(input logic v);
    ratio_wr = 1; ratio_wdata = v; @(negedge clk); ratio_wr = 0;
  endtask

  // kind: 1 = interrupt only, 2 = reset only, 3 = both
  task automatic wait_pulse(output int k, output int kind);
    k = -1; kind = 0;
    for (int i = 1; i <= 4000; i++) begin
      @(negedge clk);
      if (wdt_irq || wdt_rst) begin
        k = i; kind = {30'd0, wdt_rst, wdt_irq};
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int k, kind, snap;
    bit early;
    rst_n = 0;
    do_reset();

    // R1: reset state and idle before first refresh
    chk("R1 count after reset", count_value, FULL);
    chk("R1 rst_sel after reset", rst_sel, 0);
    chk("R1 src_sel after reset", src_sel, 0);
    chk("R1 prot_en after reset", prot_en, 0);
    early = 0;
    repeat (50) begin
      @(negedge clk);
      if (wdt_irq || wdt_rst || count_value != FULL) early = 1;
    end
    chk("R1 idle without refresh", early, 0);

    // R2/R3: low ratio, prescaler still at phase zero after idling
    pulse_refresh();
    chk("R2 reload on refresh", count_value, FULL);
    wait_pulse(k, kind);
    chk("R3 low-ratio period", k, DLO * N);
    chk("R5 interrupt kind", kind, 1);
    wait_pulse(k, kind);
    chk("R10 next period after underflow", k, DLO * N);

    // R3: high ratio
    do_reset();
    wr_ratio(1);
    pulse_refresh();
    wait_pulse(k, kind);
    chk("R3 high-ratio period", k, DHI * N);

    // R4: sub-clock ignores ratio bit
    do_reset();
    cpu_on_sub = 1;
    wr_ratio(1);
    pulse_refresh();
    wait_pulse(k, kind);
    chk("R4 sub-clock period ratio=1", k, DSUB * N);
    do_reset();
    cpu_on_sub = 1;
    pulse_refresh();
    wait_pulse(k, kind);
    chk("R4 sub-clock period ratio=0", k, DSUB * N);

    // R2: refresh keeps prescaler phase
    do_reset();
    pulse_refresh();
    repeat (40) @(negedge clk);
    chk("R3 count after 40 cycles", count_value, FULL - 40 / DLO);
    pulse_refresh();
    chk("R2 refresh mid-count", count_value, FULL);
    @(negedge clk);
    @(negedge clk);
    chk("R2 no decrement before phase", count_value, FULL);
    @(negedge clk);
    chk("R2 decrement on kept phase", count_value, FULL - 1);

    // R9: hold freezes and resumes
    do_reset();
    pulse_refresh();
    repeat (10) @(negedge clk);
    chk("R9 count before hold", count_value, FULL - 10 / DLO);
    hold = 1;
    snap = count_value;
    repeat (20) @(negedge clk);
    chk("R9 frozen during hold", count_value, snap);
    hold = 0;
    wait_pulse(k, kind);
    chk("R9 stretched period", k, DLO * N - 10);

    // R5/R6: reset action, sticky bit
    do_reset();
    wr_prot(1);
    chk("R7 protect bit set", prot_en, 1);
    wr_mode(1, 0);
    chk("R6 action bit set", rst_sel, 1);
    pulse_refresh();
    wait_pulse(k, kind);
    chk("R5 reset-mode period", k, DLO * N);
    chk("R5 reset kind", kind, 2);
    @(negedge clk);
    chk("R5 reset pulse one cycle", wdt_rst, 0);
    wr_mode(0, 0);
    chk("R6 action bit not cleared", rst_sel, 1);

    // R7: protect gate
    do_reset();
    wr_mode(1, 1);
    chk("R7 locked write rst_sel", rst_sel, 0);
    chk("R7 locked write src_sel", src_sel, 0);
    wr_prot(1);
    wr_mode(1, 1);
    chk("R7 open write rst_sel", rst_sel, 1);
    chk("R7 open write src_sel", src_sel, 1);
    wr_prot(0);
    chk("R7 protect bit cleared", prot_en, 0);
    wr_mode(1, 0);
    chk("R7 locked src_sel kept", src_sel, 1);

    // R8: protective mode counts oscillator strobes only
    pulse_refresh();
    repeat (100) @(negedge clk);
    chk("R8 no count without oscillator", count_value, FULL);
    early = 0;
    for (int i = 1; i <= N; i++) begin
      osc_tick = 1;
      @(negedge clk);
      osc_tick = 0;
      if (i == 5) chk("R8 count after 5 strobes", count_value, FULL - 5);
      if (i < N && (wdt_rst || wdt_irq)) early = 1;
      if (i == N) chk("R8 reset after full strobes", wdt_rst, 1);
    end
    chk("R8 no early request", early, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule